// File: doc/BRIEF.md
# Twin-Predicated Compress/Expand Mover

This block moves elements inside a 128-entry, 64-bit register file under the control of two independent predicate masks. One mask governs where elements are read from and the other governs where results land. A source cursor and a destination cursor each step over positions whose mask bit is clear. Every time both cursors rest on enabled positions, one element is read, passed through a small single-source operation and written. The operation is a plain move, a sign extension of the low 32 bits, or an add of a signed 16-bit immediate.

Either side can be tagged scalar, which pins its cursor to the base register and makes it ignore its mask. Combining the two tags with the two masks gives one datapath for several patterns. A sparse source with a dense destination compacts elements. A dense source with a sparse destination scatters them outward. A scalar source with a vector destination broadcasts, or inserts when only one destination bit is set. A vector source with a scalar destination selects a single element.

The register file is loaded and inspected through a host write port and a combinational host read port. A run is launched with a one-cycle `start` and ends with a one-cycle `done`.

Top module: `twin_pred_mover`

## Requirements
- R1: After reset, `busy` and `done` are both 0.
- R2: Each transfer writes op(reg[(src_base+i) mod 128]) into reg[(dst_base+j) mod 128]. The `op_sel` encodings are: 0 = move, 1 = sign-extend bits 31:0 to 64 bits, 2 = add `imm` sign-extended to 64 bits (mod 2^64), 3 = move.
- R3: With `src_vec`=1, a step in which source mask bit i is 0 only increments i. With `src_vec`=0, i stays 0 and `src_mask` has no effect.
- R4: With `dst_vec`=1 and the source side ready, a step in which destination mask bit j is 0 only increments j. With `dst_vec`=0, j stays 0 and `dst_mask` has no effect.
- R5: After a transfer, i increments only when `src_vec`=1, and j increments only when `dst_vec`=1.
- R6: With `dst_vec`=0, the run ends right after its first transfer, so exactly one register is written.
- R7: The run ends without a further write as soon as i or j is at or above the effective VL, where the effective VL is `vl` limited to 64. A `vl` of 0 writes nothing.
- R8: A `start` seen while idle is accepted on that clock edge. Each later edge performs exactly one action: a source skip, a destination skip, a transfer, or (for a run not ended by R6) a final end step. So `done` rises on the K-th edge after the accepting edge, where K is the number of such actions.
- R9: `done` is high for exactly one cycle, and `busy` is 0 in that cycle.
- R10: While `busy` is 1, `start` and all operation inputs are ignored.
- R11: A host write with `host_we`=1 stores `host_wdata` at `host_waddr` on the next edge. `host_rdata` always shows the register at `host_raddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a run (sampled while idle) |
| vl | input | 7 | Requested vector length, 0..127 (limited to 64) |
| src_base | input | 7 | Source base register |
| dst_base | input | 7 | Destination base register |
| src_vec | input | 1 | 1 = source is a vector |
| dst_vec | input | 1 | 1 = destination is a vector |
| src_mask | input | 64 | Source predicate, bit n for element n |
| dst_mask | input | 64 | Destination predicate, bit n for element n |
| op_sel | input | 2 | Element operation select |
| imm | input | 16 | Signed immediate for the add operation |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| host_we | input | 1 | Host register write enable |
| host_waddr | input | 7 | Host write address |
| host_wdata | input | 64 | Host write data |
| host_raddr | input | 7 | Host read address |
| host_rdata | output | 64 | Register contents at host_raddr |

## Verification
The bench works out K for each run: every skip, every transfer, and a final end step unless a scalar destination closed the run. It then requires `done` exactly K rising edges after the edge that took `start`. It samples 1 ns after each edge, so an output is read only after the register that drives it has been updated. Register contents are compared through the combinational read port after `done`, 1 ns after the address is set. The one-cycle width of `done` is confirmed on the next edge.

// File: rtl/tpm_pkg.sv
package tpm_pkg;

   typedef enum logic [1:0] {
      OP_MOVE  = 2'd0,
      OP_SEXTW = 2'd1,
      OP_ADDI  = 2'd2,
      OP_SPARE = 2'd3
   } op_e;

   typedef enum logic [1:0] {
      ACT_END      = 2'd0,
      ACT_SKIP_SRC = 2'd1,
      ACT_SKIP_DST = 2'd2,
      ACT_XFER     = 2'd3
   } act_e;

endpackage

// File: rtl/tpm_regfile.sv
module tpm_regfile #(
   parameter int NREG = 128,
   parameter int XLEN = 64,
   localparam int AW  = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            we,
   input  logic [AW-1:0]   waddr,
   input  logic [XLEN-1:0] wdata,
   input  logic [AW-1:0]   raddr_a,
   output logic [XLEN-1:0] rdata_a,
   input  logic [AW-1:0]   raddr_b,
   output logic [XLEN-1:0] rdata_b
);

   logic [XLEN-1:0] mem [NREG];

   initial begin
      assert (NREG == (1 << AW)) else $error("tpm_regfile: NREG must be a power of two");
   end

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata_a = mem[raddr_a];
   assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/tpm_alu.sv
module tpm_alu
   import tpm_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int IMM_W = 16
) (
   input  op_e              op,
   input  logic [XLEN-1:0]  a,
   input  logic [IMM_W-1:0] imm,
   output logic [XLEN-1:0]  y
);

   logic [XLEN-1:0] sext_w;
   logic [XLEN-1:0] imm_x;

   initial begin
      assert (XLEN >= IMM_W) else $error("tpm_alu: XLEN narrower than immediate");
   end

   generate
      if (XLEN > 32) begin : g_wide
         assign sext_w = {{(XLEN-32){a[31]}}, a[31:0]};
      end else begin : g_narrow
         assign sext_w = a;
      end
      if (XLEN > IMM_W) begin : g_immx
         assign imm_x = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
      end else begin : g_immeq
         assign imm_x = imm;
      end
   endgenerate

   always_comb begin
      unique case (op)
         OP_SEXTW: y = sext_w;
         OP_ADDI:  y = a + imm_x;
         default:  y = a;
      endcase
   end

endmodule

// File: rtl/tpm_step.sv
module tpm_step
   import tpm_pkg::*;
#(
   parameter int MAXVL = 64,
   localparam int VLW  = $clog2(MAXVL + 1),
   localparam int MW   = $clog2(MAXVL)
) (
   input  logic [VLW-1:0]   vl,
   input  logic [VLW-1:0]   i,
   input  logic [VLW-1:0]   j,
   input  logic             svec,
   input  logic             dvec,
   input  logic [MAXVL-1:0] smask,
   input  logic [MAXVL-1:0] dmask,
   output act_e             act
);

   logic src_off, dst_off;

   initial begin
      assert (MAXVL == (1 << MW)) else $error("tpm_step: MAXVL must be a power of two");
   end

   assign src_off = svec && !smask[i[MW-1:0]];
   assign dst_off = dvec && !dmask[j[MW-1:0]];

   always_comb begin
      if (i >= vl || j >= vl) act = ACT_END;
      else if (src_off)       act = ACT_SKIP_SRC;
      else if (dst_off)       act = ACT_SKIP_DST;
      else                    act = ACT_XFER;
   end

endmodule

// File: rtl/twin_pred_mover.sv
module twin_pred_mover
   import tpm_pkg::*;
#(
   parameter int NREG  = 128,
   parameter int XLEN  = 64,
   parameter int MAXVL = 64,
   parameter int IMM_W = 16,
   localparam int AW   = $clog2(NREG),
   localparam int VLW  = $clog2(MAXVL + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [VLW-1:0]   vl,
   input  logic [AW-1:0]    src_base,
   input  logic [AW-1:0]    dst_base,
   input  logic             src_vec,
   input  logic             dst_vec,
   input  logic [MAXVL-1:0] src_mask,
   input  logic [MAXVL-1:0] dst_mask,
   input  logic [1:0]       op_sel,
   input  logic [IMM_W-1:0] imm,
   output logic             busy,
   output logic             done,
   input  logic             host_we,
   input  logic [AW-1:0]    host_waddr,
   input  logic [XLEN-1:0]  host_wdata,
   input  logic [AW-1:0]    host_raddr,
   output logic [XLEN-1:0]  host_rdata
);

   localparam logic [VLW-1:0] VL_CAP = VLW'(MAXVL);

   logic             busy_q, done_q;
   logic [VLW-1:0]   vl_q, i_q, j_q;
   logic [AW-1:0]    sb_q, db_q;
   logic             sv_q, dv_q;
   logic [MAXVL-1:0] sm_q, dm_q;
   op_e              op_q;
   logic [IMM_W-1:0] imm_q;

   act_e             act;
   logic             eng_we;
   logic [AW-1:0]    src_addr, dst_addr, rf_waddr;
   logic [XLEN-1:0]  src_data, alu_y, rf_wdata;

   initial begin
      assert (NREG >= MAXVL) else $error("twin_pred_mover: register file smaller than MAXVL");
   end

   tpm_step #(.MAXVL(MAXVL)) u_step (
      .vl(vl_q), .i(i_q), .j(j_q), .svec(sv_q), .dvec(dv_q),
      .smask(sm_q), .dmask(dm_q), .act(act)
   );

   assign src_addr = sb_q + AW'(i_q);
   assign dst_addr = db_q + AW'(j_q);
   assign eng_we   = busy_q && (act == ACT_XFER);
   assign rf_waddr = eng_we ? dst_addr : host_waddr;
   assign rf_wdata = eng_we ? alu_y    : host_wdata;

   tpm_alu #(.XLEN(XLEN), .IMM_W(IMM_W)) u_alu (
      .op(op_q), .a(src_data), .imm(imm_q), .y(alu_y)
   );

   tpm_regfile #(.NREG(NREG), .XLEN(XLEN)) u_rf (
      .clk(clk), .we(eng_we || host_we), .waddr(rf_waddr), .wdata(rf_wdata),
      .raddr_a(src_addr), .rdata_a(src_data),
      .raddr_b(host_raddr), .rdata_b(host_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         vl_q   <= '0;
         i_q    <= '0;
         j_q    <= '0;
         sb_q   <= '0;
         db_q   <= '0;
         sv_q   <= 1'b0;
         dv_q   <= 1'b0;
         sm_q   <= '0;
         dm_q   <= '0;
         op_q   <= OP_MOVE;
         imm_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start) begin
               busy_q <= 1'b1;
               vl_q   <= (vl > VL_CAP) ? VL_CAP : vl;
               i_q    <= '0;
               j_q    <= '0;
               sb_q   <= src_base;
               db_q   <= dst_base;
               sv_q   <= src_vec;
               dv_q   <= dst_vec;
               sm_q   <= src_mask;
               dm_q   <= dst_mask;
               op_q   <= op_e'(op_sel);
               imm_q  <= imm;
            end
         end else begin
            unique case (act)
               ACT_END: begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end
               ACT_SKIP_SRC: i_q <= i_q + 1'b1;
               ACT_SKIP_DST: j_q <= j_q + 1'b1;
               default: begin
                  if (sv_q) i_q <= i_q + 1'b1;
                  if (dv_q) j_q <= j_q + 1'b1;
                  else begin
                     busy_q <= 1'b0;
                     done_q <= 1'b1;
                  end
               end
            endcase
         end
      end
   end

   assign busy = busy_q;
   assign done = done_q;

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !busy_q);

   p_accept_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && start) |=> busy_q);

   p_scalar_dst_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && act == ACT_XFER && !dv_q) |=> (done_q && !busy_q));

   p_src_scalar_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !sv_q) |-> (i_q == '0));

   p_dst_scalar_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !dv_q) |-> (j_q == '0));

   p_index_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (i_q <= vl_q && j_q <= vl_q && vl_q <= VL_CAP));

   p_ignore_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && start) |=> (sb_q == $past(sb_q) && db_q == $past(db_q) && vl_q == $past(vl_q)));

endmodule

// File: tb/tb_twin_pred_mover.sv
module tb_twin_pred_mover;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [6:0]  vl = '0;
   logic [6:0]  src_base = '0, dst_base = '0;
   logic        src_vec = 1'b0, dst_vec = 1'b0;
   logic [63:0] src_mask = '0, dst_mask = '0;
   logic [1:0]  op_sel = '0;
   logic [15:0] imm = '0;
   logic        busy, done;
   logic        host_we = 1'b0;
   logic [6:0]  host_waddr = '0, host_raddr = '0;
   logic [63:0] host_wdata = '0;
   logic [63:0] host_rdata;

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   logic [63:0] model [128];

   always #5 clk = ~clk;

   twin_pred_mover dut (
      .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
      .src_base(src_base), .dst_base(dst_base),
      .src_vec(src_vec), .dst_vec(dst_vec),
      .src_mask(src_mask), .dst_mask(dst_mask),
      .op_sel(op_sel), .imm(imm), .busy(busy), .done(done),
      .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
      .host_raddr(host_raddr), .host_rdata(host_rdata)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] ref_op(input int op, input logic [63:0] a, input logic [15:0] k);
      case (op)
         1: return {{32{a[31]}}, a[31:0]};
         2: return a + {{48{k[15]}}, k};
         default: return a;
      endcase
   endfunction

   task automatic host_write(input int a, input logic [63:0] d);
      @(negedge clk);
      host_we = 1'b1; host_waddr = 7'(a); host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
      model[a] = d;
   endtask

   task automatic fill_all(input logic [31:0] seed);
      for (int a = 0; a < 128; a++)
         host_write(a, {32'(a) * 32'h9E3779B1 ^ seed, (32'(a) + seed) * 32'h85EBCA6B});
   endtask

   task automatic compare_rf(input string req);
      int bad = 0;
      logic [63:0] fa = '0, fe = '0;
      for (int a = 0; a < 128; a++) begin
         host_raddr = 7'(a);
         #1;
         if (host_rdata !== model[a]) begin
            if (bad == 0) begin fa = host_rdata; fe = model[a]; end
            bad++;
         end
      end
      chk(bad == 0, req, "register file contents", fa, fe);
   endtask

   // Runs one operation, predicting writes and the action count K.
   task automatic run_op(input string req, input int vlen, input int sb, input int db,
                         input bit sv, input bit dv, input logic [63:0] sm, input logic [63:0] dm,
                         input int op, input logic [15:0] k, input bit poke);
      int i = 0, j = 0, kk = 0, cnt = 0, evl;
      evl = (vlen > 64) ? 64 : vlen;
      forever begin
         if (i >= evl || j >= evl) begin kk++; break; end
         if (sv && !sm[i]) begin i++; kk++; continue; end
         if (dv && !dm[j]) begin j++; kk++; continue; end
         model[(db + j) % 128] = ref_op(op, model[(sb + i) % 128], k);
         kk++;
         if (sv) i++;
         if (dv) j++;
         else break;
      end
      @(negedge clk);
      vl = 7'(vlen); src_base = 7'(sb); dst_base = 7'(db);
      src_vec = sv; dst_vec = dv; src_mask = sm; dst_mask = dm;
      op_sel = 2'(op); imm = k; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1, "R8", "busy after accept", 64'(busy), 64'd1);
      while (cnt < 400) begin
         @(posedge clk);
         #1;
         cnt++;
         if (poke && cnt == 2) begin
            start = 1'b1; dst_base = 7'(db + 40); vl = 7'd3; op_sel = 2'd2; src_vec = ~sv;
         end
         if (poke && cnt == 3) start = 1'b0;
         if (done === 1'b1) break;
      end
      chk(cnt == kk, "R8", "cycles until done", 64'(cnt), 64'(kk));
      chk(busy === 1'b0, "R9", "busy low with done", 64'(busy), 64'd0);
      @(posedge clk);
      #1;
      chk(done === 1'b0, "R9", "done width one cycle", 64'(done), 64'd0);
      compare_rf(req);
   endtask

   task automatic t_reset;
      chk(busy === 1'b0, "R1", "busy after reset", 64'(busy), 64'd0);
      chk(done === 1'b0, "R1", "done after reset", 64'(done), 64'd0);
   endtask

   task automatic t_host_port;
      host_write(5, 64'hDEAD_BEEF_0123_4567);
      host_raddr = 7'd5;
      #1;
      chk(host_rdata === 64'hDEAD_BEEF_0123_4567, "R11", "host readback", host_rdata, 64'hDEAD_BEEF_0123_4567);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #1;
      t_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_host_port();
      fill_all(32'h1357_9BDF);
      // R3 R5: compress, sparse source into dense destination
      run_op("R3", 8, 10, 40, 1, 1, 64'hB6, 64'hFFFF_FFFF_FFFF_FFFF, 0, 16'h0, 0);
      // R4: expand, dense source into sparse destination
      run_op("R4", 8, 20, 50, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h5A, 0, 16'h0, 0);
      // R3 R4: both masks sparse, exhaustion by source cursor (R7)
      run_op("R7", 10, 0, 70, 1, 1, 64'h0000_0000_0000_0033, 64'h0000_0000_0000_03CC, 1, 16'h0, 0);
      // R2 R5: splat with add of negative immediate
      run_op("R2", 5, 3, 90, 0, 1, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 2, 16'hFFFD, 0);
      // R4 R3: insert, scalar source ignores its mask
      run_op("R4", 8, 7, 100, 0, 1, 64'h0, 64'h40, 0, 16'h0, 0);
      // R6: select element 4 into a scalar destination, dst mask ignored
      run_op("R6", 8, 30, 60, 1, 0, 64'h10, 64'h0, 0, 16'h0, 0);
      // R2 R6: scalar to scalar with sign extension
      run_op("R2", 6, 9, 11, 0, 0, 64'h0, 64'h0, 1, 16'h0, 0);
      // R7: zero length writes nothing
      run_op("R7", 0, 1, 2, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2, 16'h7, 0);
      // R7: length above 64 limited to 64
      run_op("R7", 100, 0, 64, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, 16'h0, 0);
      // R2: destination wraps around the register file
      run_op("R2", 12, 40, 120, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2, 16'h0100, 0);
      // R10: start and inputs changed while busy
      run_op("R10", 16, 16, 80, 1, 1, 64'hF0F0, 64'hFFFF, 0, 16'h0, 1);
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule